// File: doc/BRIEF.md
# Configurable Port Interrupt Controller

This block turns changes on eight general-purpose port lines and on one separate external pin into a single interrupt request for a host processor. A port line can raise an interrupt only when the host has set it as an input and has set its enable bit. The external pin has its own enable bit. Each source has a trigger condition: an active low level, an active high level, a falling edge or a rising edge. The lower four port lines share one mode setting, the upper four share a second, and the external pin has a third.

When a source's condition is seen, a sticky status bit records it. New causes add to the status as they arrive. The host clears a bit by writing 1 to it through an acknowledge write, but the clear only happens if the condition is no longer present in that cycle. The request output is high while any status bit is set. It drops for exactly one clock after every acknowledge write. An acknowledge that leaves status nonzero therefore shows up as a new rising edge on the request.

The host reaches the block through a simple synchronous register port. Register writes take effect at the clock edge. Read data is registered and appears one clock after the address is presented.

Top module: `port_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the direction, enable and mode registers, every status bit, `irq_req` and `reg_rdata` are all 0.
- R2: A port source can set its status bit only while both its direction bit (address 0, 1 = input) and its enable bit (address 1) are 1. The external source can set its status bit only while mode-register bit 6 is 1.
- R3: Mode code 00 triggers while the synchronized input is 0. Mode code 01 triggers while the synchronized input is 1.
- R4: Mode code 10 triggers only in the one cycle in which a 1-to-0 change of the synchronized input is seen. Mode code 11 does the same for a 0-to-1 change.
- R5: Mode-register bits [1:0] set the mode of port lines 3..0, bits [3:2] set lines 7..4, and bits [5:4] set the external source. Each group follows its own field.
- R6: Status bits are sticky. Once set, a bit stays set when its condition goes away, and new causes are added to the bits already set.
- R7: Writing to address 4 acknowledges the port sources. A status bit is cleared only if its data bit is 1 and its condition is absent in that cycle. Data bits that are 0 leave their status bits unchanged.
- R8: If a source's condition is still present at acknowledge time, its status bit stays 1.
- R9: `irq_req` is 0 in the cycle after any acknowledge write, which is any write to address 4 or a mode-register write with bit 7 set. In every other cycle it equals the OR of all status bits.
- R10: In the mode register, bit 7 reads as the external status bit. Writing 1 to bit 7 acknowledges the external source under the same rule as R7.
- R11: `reg_rdata` shows the addressed register one cycle after the address is applied. Address 0 returns direction, 1 returns enable, 2 returns the mode register, 3 returns port status and 4 reads as 0. Writes to address 3 change nothing.
- R12: Every input passes through a two-flop synchronizer. A pin change applied before clock edge k becomes visible in status and `irq_req` after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for the address of the previous cycle |
| port_in | input | 8 | Asynchronous port input lines |
| ext_in | input | 1 | Asynchronous external interrupt pin |
| irq_req | output | 1 | Interrupt request to the host |

## Verification
A pin change applied before edge k moves status and `irq_req` after edge k+2. A register write, including an acknowledge, changes status, `irq_req` and the register contents at the edge on which it is written. Read data lags the address by one edge. The bench drives every input on the falling edge and advances a behavioural model in step with the design. It compares `irq_req` and `reg_rdata` against that model a little after each rising edge, so every latency above is checked on every cycle rather than at hand-picked sample points.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    MD_LVL_LO = 2'b00,
    MD_LVL_HI = 2'b01,
    MD_FALL   = 2'b10,
    MD_RISE   = 2'b11
  } trig_mode_e;

  localparam int A_DIR  = 0;
  localparam int A_IEN  = 1;
  localparam int A_MODE = 2;
  localparam int A_STAT = 3;
  localparam int A_ACK  = 4;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      prv <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      prv <= stg[STAGES-1];
    end
  end

  assign cur = stg[STAGES-1];
endmodule

// File: rtl/pic_cond.sv
module pic_cond
  import pic_pkg::*;
(
  input  trig_mode_e mode,
  input  logic       cur,
  input  logic       prv,
  input  logic       active,
  output logic       hit
);
  logic raw;

  always_comb begin
    unique case (mode)
      MD_LVL_LO: raw = ~cur;
      MD_LVL_HI: raw = cur;
      MD_FALL:   raw = prv & ~cur;
      MD_RISE:   raw = ~prv & cur;
      default:   raw = 1'b0;
    endcase
  end

  assign hit = raw & active;
endmodule

// File: rtl/port_irq_ctrl.sv
module port_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NPORT  = 8,
  parameter int GRP_W  = 4,
  parameter int AW     = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [NPORT-1:0] reg_wdata,
  output logic [NPORT-1:0] reg_rdata,
  input  logic [NPORT-1:0] port_in,
  input  logic             ext_in,
  output logic             irq_req
);
  localparam int NSRC   = NPORT + 1;
  localparam int NGRP   = NPORT / GRP_W;
  localparam int EXT_MD = 2 * NGRP;
  localparam int EXT_EN = EXT_MD + 2;
  localparam int MW     = NPORT - 1;

  logic [NPORT-1:0] dir_q, ien_q;
  logic [MW-1:0]    mode_q;
  logic [NSRC-1:0]  st_q, st_d;
  logic [NSRC-1:0]  s_cur, s_prv, active, cond, ackv;
  logic             ack_evt, wr_mode, wr_ack;

  pic_sync #(.W(NSRC), .STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({ext_in, port_in}),
    .cur (s_cur),
    .prv (s_prv)
  );

  assign active = {mode_q[EXT_EN], dir_q & ien_q};

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_src
      localparam int MB = (gi == NPORT) ? EXT_MD : 2 * (gi / GRP_W);
      pic_cond u_cond (
        .mode   (trig_mode_e'(mode_q[MB +: 2])),
        .cur    (s_cur[gi]),
        .prv    (s_prv[gi]),
        .active (active[gi]),
        .hit    (cond[gi])
      );
    end
  endgenerate

  assign wr_mode = reg_we && (reg_addr == AW'(A_MODE));
  assign wr_ack  = reg_we && (reg_addr == AW'(A_ACK));
  assign ack_evt = wr_ack || (wr_mode && reg_wdata[NPORT-1]);
  assign ackv    = {wr_mode & reg_wdata[NPORT-1], wr_ack ? reg_wdata : '0};

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      if (cond[i])      st_d[i] = 1'b1;
      else if (ackv[i]) st_d[i] = 1'b0;
      else              st_d[i] = st_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q     <= '0;
      ien_q     <= '0;
      mode_q    <= '0;
      st_q      <= '0;
      irq_req   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      st_q    <= st_d;
      irq_req <= ack_evt ? 1'b0 : |st_d;
      if (reg_we && reg_addr == AW'(A_DIR)) dir_q <= reg_wdata;
      if (reg_we && reg_addr == AW'(A_IEN)) ien_q <= reg_wdata;
      if (wr_mode) mode_q <= reg_wdata[MW-1:0];
      case (reg_addr)
        AW'(A_DIR):  reg_rdata <= dir_q;
        AW'(A_IEN):  reg_rdata <= ien_q;
        AW'(A_MODE): reg_rdata <= {st_q[NPORT], mode_q};
        AW'(A_STAT): reg_rdata <= st_q[NPORT-1:0];
        default:     reg_rdata <= '0;
      endcase
    end
  end

  a_r9_ack_drops_req: assert property (@(posedge clk) disable iff (rst)
    ack_evt |=> !irq_req);

  a_r9_req_tracks_status: assert property (@(posedge clk) disable iff (rst)
    !$past(ack_evt) |-> (irq_req == (|st_q)));

  a_r8_cond_keeps_status: assert property (@(posedge clk) disable iff (rst)
    (cond != '0) |=> ((st_q & $past(cond)) == $past(cond)));

  a_r2_set_needs_active: assert property (@(posedge clk) disable iff (rst)
    (st_q & ~$past(st_q) & ~$past(active)) == '0);

  a_r7_clear_needs_ack: assert property (@(posedge clk) disable iff (rst)
    (~st_q & $past(st_q) & ~$past(ackv)) == '0);
endmodule

// File: tb/sim_port_irq_ctrl.sv
module sim_port_irq_ctrl;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [7:0] port_in = 8'd0;
  logic       ext_in = 1'b0;
  logic       irq_req;

  int    vectors = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  bit [8:0] m_s1, m_s2, m_p, m_st;
  bit [7:0] m_dir, m_ien, m_rd;
  bit [6:0] m_mode;
  bit       m_irq;
  bit [7:0] pin_v = 8'd0;
  bit       ext_v = 1'b0;

  port_irq_ctrl u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_in(port_in),
    .ext_in(ext_in), .irq_req(irq_req)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic bit trig(bit [1:0] md, bit c, bit pv);
    case (md)
      2'd0: return !c;
      2'd1: return c;
      2'd2: return pv && !c;
      default: return !pv && c;
    endcase
  endfunction

  task automatic model(bit r, bit we, int addr, bit [7:0] wd);
    bit [8:0] cnd, ak, nst;
    bit       evt;
    if (r) begin
      m_s1 = 0; m_s2 = 0; m_p = 0; m_st = 0;
      m_dir = 0; m_ien = 0; m_mode = 0; m_irq = 0; m_rd = 0;
      return;
    end
    for (int i = 0; i < 9; i++) begin
      int  fld;
      bit  on;
      fld = (i == 8) ? 4 : ((i < 4) ? 0 : 2);
      on  = (i == 8) ? m_mode[6] : (m_dir[i] && m_ien[i]);
      cnd[i] = on && trig(m_mode[fld +: 2], m_s2[i], m_p[i]);
    end
    ak = 0;
    if (we && addr == 4) ak[7:0] = wd;
    if (we && addr == 2) ak[8] = wd[7];
    evt = we && (addr == 4 || (addr == 2 && wd[7]));
    for (int i = 0; i < 9; i++)
      nst[i] = cnd[i] ? 1'b1 : (ak[i] ? 1'b0 : m_st[i]);
    case (addr)
      0: m_rd = m_dir;
      1: m_rd = m_ien;
      2: m_rd = {m_st[8], m_mode};
      3: m_rd = m_st[7:0];
      default: m_rd = 8'd0;
    endcase
    m_irq = evt ? 1'b0 : (nst != 0);
    m_st  = nst;
    if (we && addr == 0) m_dir = wd;
    if (we && addr == 1) m_ien = wd;
    if (we && addr == 2) m_mode = wd[6:0];
    m_p  = m_s2;
    m_s2 = m_s1;
    m_s1 = {ext_v, pin_v};
  endtask

  task automatic step(bit we, int addr, bit [7:0] wd);
    @(negedge clk);
    reg_we = we; reg_addr = 3'(addr); reg_wdata = wd;
    port_in = pin_v; ext_in = ext_v;
    model(rst, we, addr, wd);
    @(posedge clk);
    #1;
    vectors++;
    if (irq_req !== m_irq || reg_rdata !== m_rd) begin
      errors++;
      $display("FAIL %s: irq_req=%0b rdata=%02h, expected irq_req=%0b rdata=%02h",
               cur_req, irq_req, reg_rdata, m_irq, m_rd);
    end
  endtask

  task automatic wr(int a, bit [7:0] d); step(1'b1, a, d); endtask
  task automatic rd(int a); step(1'b0, a, 8'd0); endtask
  task automatic idle(int n); for (int k = 0; k < n; k++) step(1'b0, 3, 8'd0); endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    for (int a = 0; a < 5; a++) rd(a);

    // R2: gating by direction and enable
    cur_req = "R2";
    wr(1, 8'hFF); idle(4);
    wr(1, 8'h00); wr(0, 8'hFF); idle(4); rd(3);
    wr(0, 8'h0F); wr(1, 8'h03); idle(4); rd(3);

    // R8: condition still present at acknowledge
    cur_req = "R8";
    wr(4, 8'h03); idle(3); rd(3);

    // R7: clear needs 1 and absent condition; zero bits no effect
    cur_req = "R7";
    pin_v = 8'h01; idle(4);
    wr(4, 8'h00); rd(3);
    wr(4, 8'h01); rd(3);
    pin_v = 8'h03; idle(3);
    wr(4, 8'h02); rd(3); idle(2);

    // R3 / R5: level high on low nibble, level low on high nibble
    cur_req = "R3";
    pin_v = 8'h00;
    wr(2, 8'h01); wr(0, 8'hFF); wr(1, 8'hFF); idle(4); rd(3);
    cur_req = "R5";
    pin_v = 8'hF3; idle(4); rd(3);
    wr(4, 8'hFF); idle(2); rd(3);
    pin_v = 8'hF0; idle(4);
    wr(4, 8'hFF); rd(3); idle(2);

    // R4 / R12: edge modes, low nibble rising, high nibble falling
    cur_req = "R4";
    pin_v = 8'h00; wr(2, 8'h0B); idle(4);
    wr(4, 8'hFF); idle(2); rd(3);
    cur_req = "R12";
    pin_v = 8'h01; idle(1); rd(3); rd(3); rd(3);
    cur_req = "R4";
    pin_v = 8'h00; idle(4);
    pin_v = 8'h10; idle(4);
    pin_v = 8'h00; idle(4); rd(3);
    cur_req = "R6";
    pin_v = 8'h02; idle(4); rd(3);
    cur_req = "R7";
    wr(4, 8'hFF); idle(2); rd(3);

    // R10: external source through the mode register
    cur_req = "R10";
    wr(2, 8'h4B); idle(4); rd(2);
    wr(2, 8'hCB); idle(1); rd(2);
    ext_v = 1'b1; idle(4);
    wr(2, 8'hCB); idle(1); rd(2);
    wr(2, 8'h7B); ext_v = 1'b0; idle(4);
    ext_v = 1'b1; idle(4); rd(2);
    wr(2, 8'hFB); rd(2); idle(2);
    wr(2, 8'h3B); ext_v = 1'b0; idle(4); rd(2);

    // R11: register access
    cur_req = "R11";
    wr(3, 8'hFF); rd(3); rd(4); rd(0); rd(1); rd(2);
    wr(0, 8'hA5); wr(1, 8'h5A); rd(0); rd(1);
    wr(1, 8'h00); wr(4, 8'hFF); idle(3);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule